// File: doc/BRIEF.md
# Receive Frame Page Packer

The packer takes one received Ethernet frame as a byte stream and lays it out in a fixed-size packet page of 2048 bytes. Each page has a four-byte header, then the frame data, an optional frame check sequence and a two-byte tail. The header holds a status word and a byte count. Frames shorter than the minimum length are padded with zeros. When the check sequence is kept, it is computed over the padded data and written in after the even part of the frame. For a long odd-length frame, the final data byte is moved behind the check sequence and marked by the tail control byte.

Another block allocates the page and supplies its number at the start of each frame. The packer then sends a stream of single-byte page writes. It writes the data area while bytes arrive, and it writes the pad, check sequence, tail and header once the last byte has been seen. During that time the input stream is held off. The packer ends each frame with exactly one of two pulses. A completion pulse also serves as the receive interrupt request. A reject pulse marks a frame that was not stored because reception was off, the soft reset was held, or the frame would not fit in the page.

Top module: `rxpk_top`

## Requirements
- R1: A frame is taken only when `rx_enable` is 1 and `soft_reset` is 0 as its first byte is accepted. Otherwise it causes no page write at all and ends with a reject pulse.
- R2: Page offsets 0 (low byte) and 1 (high byte) hold a status word. Bit 11 (0x0800) is set when the frame is longer than 1518 bytes. Bit 12 (0x1000) is set when the frame length is odd. All other bits are 0.
- R3: Offsets 2 (low byte) and 3 (high byte) hold the byte count. The count is D + 6, plus 4 more when the check sequence is kept. D is 64 for a frame shorter than 64 bytes; otherwise D is the frame length rounded down to even.
- R4: Frame byte i is stored at offset 4+i. A frame shorter than 64 bytes is zero-filled up to offset 67. For a short odd frame, the last byte stays at its own position.
- R5: When `strip_crc` is 0, a CRC-32 is stored at offsets 4+D to 7+D, low byte first. The CRC uses the reflected polynomial 0x04C11DB7, a seed of all ones and a final inversion. It covers the padded data for a short frame and every frame byte for a long frame. When `strip_crc` is 1, no CRC is stored.
- R6: The last two bytes of the stored area (offsets count-2 and count-1) form the tail. For an odd frame of 64 bytes or more, the tail is the final frame byte followed by 0x60. In every other case, it is 0x00 followed by 0x40.
- R7: A frame whose byte count would exceed 2048 ends with a reject pulse. For such a frame, offsets 0 to 3 are never written.
- R8: Each accepted frame gives exactly one single-cycle `rx_done` pulse, in the cycle right after its final page write. Each rejected frame gives exactly one `rx_drop` pulse. The two pulses never occur together.
- R9: Every write of a frame carries the page number sampled with its first byte. A stored frame writes each offset below its byte count exactly once, and writes nothing else.
- R10: `s_ready` is 1 when idle and stays 0 from the cycle after the last byte until the end pulse. A byte offered without `s_first` while idle is consumed and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_enable | input | 1 | Reception on; sampled with the first byte |
| soft_reset | input | 1 | Soft reset held; sampled with the first byte |
| strip_crc | input | 1 | 1: store no CRC |
| page_sel | input | PAGE_W | Allocated page number for the next frame |
| s_valid | input | 1 | Stream byte offered |
| s_data | input | 8 | Stream byte |
| s_first | input | 1 | Byte is the first of a frame |
| s_last | input | 1 | Byte is the last of a frame |
| s_ready | output | 1 | Byte accepted when high with s_valid |
| wr_en | output | 1 | Page write strobe |
| wr_page | output | PAGE_W | Page being written |
| wr_off | output | OFF_W | Byte offset within the page |
| wr_data | output | 8 | Byte written |
| rx_done | output | 1 | Frame stored; receive interrupt request |
| rx_drop | output | 1 | Frame rejected |

## Verification
Wrong internal state shows up at the ports within one frame. A stale or wrong length count moves the byte count, the CRC offset and the tail offset together. The bench sees this as holes or double writes in its page image, which it compares at the end pulse. A CRC register that is not reseeded or not updated corrupts the four CRC bytes of the very next stored frame. A wrong sequencer state shows as a missing or doubled end pulse, or as `s_ready` staying high after the last byte. Each frame is checked in full a few cycles after its end pulse, so a fault never goes unseen for more than one frame.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RECV,
        ST_CHK,
        ST_PAD,
        ST_CRC,
        ST_ODD,
        ST_CTRL,
        ST_HDR,
        ST_FIN
    } pk_state_e;

    localparam int HDR_BYTES   = 4;
    localparam int TRAIL_BYTES = 2;
    localparam int CRC_BYTES   = 4;

    localparam int STAT_LONG_BIT = 11;
    localparam int STAT_ODD_BIT  = 12;

    localparam logic [7:0] CTRL_EVEN = 8'h40;
    localparam logic [7:0] CTRL_ODD  = 8'h60;

    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // One byte through the reflected CRC-32 register, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxpk_crc.sv
module rxpk_crc
    import rxpk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [31:0] fcs
);
    logic [31:0] crc_q;
    logic [31:0] base;
    logic [31:0] crc_d;

    always_comb begin
        base  = init ? CRC_SEED : crc_q;
        crc_d = upd ? crc32_step(base, din) : base;
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= CRC_SEED;
        else     crc_q <= crc_d;
    end

    assign fcs = ~crc_q;
endmodule

// File: rtl/rxpk_len.sv
module rxpk_len
    import rxpk_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int MIN_FRAME  = 64,
    parameter int LONG_LIMIT = 1518,
    parameter int PAGE_BYTES = 2048,
    localparam int CNT_W     = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    input  logic             strip,
    output logic [LEN_W-1:0] len_q,
    output logic             is_odd,
    output logic             is_short,
    output logic [CNT_W-1:0] data_bytes,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             oversize,
    output logic [15:0]      status
);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] len_d;
    logic             is_long;

    always_comb begin
        base  = clear ? '0 : len_q;
        len_d = (inc && base != LEN_MAX) ? base + 1'b1 : base;
    end

    always_ff @(posedge clk) begin
        if (rst) len_q <= '0;
        else     len_q <= len_d;
    end

    always_comb begin
        is_odd     = len_q[0];
        is_short   = CNT_W'(len_q) < CNT_W'(MIN_FRAME);
        is_long    = CNT_W'(len_q) > CNT_W'(LONG_LIMIT);
        data_bytes = is_short ? CNT_W'(MIN_FRAME) : CNT_W'({len_q[LEN_W-1:1], 1'b0});
        byte_cnt   = data_bytes + CNT_W'(HDR_BYTES + TRAIL_BYTES)
                   + (strip ? CNT_W'(0) : CNT_W'(CRC_BYTES));
        oversize   = byte_cnt > CNT_W'(PAGE_BYTES);
        status     = '0;
        status[STAT_LONG_BIT] = is_long;
        status[STAT_ODD_BIT]  = is_odd;
    end
endmodule

// File: rtl/rxpk_top.sv
module rxpk_top
    import rxpk_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int MIN_FRAME  = 64,
    parameter int LONG_LIMIT = 1518,
    parameter int LEN_W      = 16,
    parameter int PAGE_W     = 2,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_enable,
    input  logic              soft_reset,
    input  logic              strip_crc,
    input  logic [PAGE_W-1:0] page_sel,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_first,
    input  logic              s_last,
    output logic              s_ready,
    output logic              wr_en,
    output logic [PAGE_W-1:0] wr_page,
    output logic [OFF_W-1:0]  wr_off,
    output logic [7:0]        wr_data,
    output logic              rx_done,
    output logic              rx_drop
);
    localparam int CNT_W = LEN_W + 1;

    pk_state_e         st_q, st_d;
    logic [PAGE_W-1:0] page_q;
    logic              en_q, strip_q;
    logic [7:0]        held_q;
    logic [OFF_W-1:0]  ptr_q, ptr_d;

    logic              acc, start, take, en_cur, hold, fits, pad_upd;
    logic [LEN_W-1:0]  idx;
    logic [CNT_W-1:0]  data_off;

    logic [LEN_W-1:0]  len_q;
    logic              is_odd, is_short, oversize;
    logic [CNT_W-1:0]  data_bytes, byte_cnt;
    logic [15:0]       status;
    logic [31:0]       fcs;

    logic              nx_we, go_done, go_drop;
    logic [OFF_W-1:0]  nx_off;
    logic [7:0]        nx_dat;
    logic              odd_tail;

    // Stream acceptance and per-byte placement
    assign s_ready = (st_q == ST_IDLE) || (st_q == ST_RECV);

    always_comb begin
        acc      = s_valid && s_ready;
        start    = acc && s_first && (st_q == ST_IDLE);
        take     = start || (acc && (st_q == ST_RECV));
        en_cur   = start ? (rx_enable && !soft_reset) : en_q;
        idx      = start ? '0 : len_q;
        hold     = s_last && !idx[0] && (CNT_W'(idx) >= CNT_W'(MIN_FRAME));
        data_off = CNT_W'(idx) + CNT_W'(HDR_BYTES);
        fits     = data_off < CNT_W'(PAGE_BYTES);
        pad_upd  = (st_q == ST_PAD);
        odd_tail = is_odd && !is_short;
    end

    rxpk_crc u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (start),
        .upd  ((take && en_cur) || pad_upd),
        .din  (pad_upd ? 8'h00 : s_data),
        .fcs  (fcs)
    );

    rxpk_len #(
        .LEN_W      (LEN_W),
        .MIN_FRAME  (MIN_FRAME),
        .LONG_LIMIT (LONG_LIMIT),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_len (
        .clk        (clk),
        .rst        (rst),
        .clear      (start),
        .inc        (take),
        .strip      (strip_q),
        .len_q      (len_q),
        .is_odd     (is_odd),
        .is_short   (is_short),
        .data_bytes (data_bytes),
        .byte_cnt   (byte_cnt),
        .oversize   (oversize),
        .status     (status)
    );

    // Sequencer: data bytes while streaming, then pad, CRC, tail and header
    always_comb begin
        st_d    = st_q;
        ptr_d   = ptr_q;
        nx_we   = 1'b0;
        nx_off  = '0;
        nx_dat  = 8'h00;
        go_done = 1'b0;
        go_drop = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_RECV: begin
                if (take) begin
                    nx_we  = en_cur && !hold && fits;
                    nx_off = OFF_W'(data_off);
                    nx_dat = s_data;
                    st_d   = s_last ? ST_CHK : ST_RECV;
                end
            end
            ST_CHK: begin
                if (!en_q || oversize) begin
                    go_drop = 1'b1;
                    st_d    = ST_IDLE;
                end else if (is_short) begin
                    st_d  = ST_PAD;
                    ptr_d = OFF_W'(len_q);
                end else begin
                    st_d  = strip_q ? ST_ODD : ST_CRC;
                    ptr_d = '0;
                end
            end
            ST_PAD: begin
                nx_we  = 1'b1;
                nx_off = OFF_W'(HDR_BYTES) + ptr_q;
                ptr_d  = ptr_q + 1'b1;
                if (ptr_q == OFF_W'(MIN_FRAME - 1)) begin
                    st_d  = strip_q ? ST_ODD : ST_CRC;
                    ptr_d = '0;
                end
            end
            ST_CRC: begin
                nx_we  = 1'b1;
                nx_off = OFF_W'(data_bytes + CNT_W'(HDR_BYTES)) + ptr_q;
                nx_dat = 8'(fcs >> {ptr_q[1:0], 3'b000});
                ptr_d  = ptr_q + 1'b1;
                if (ptr_q[1:0] == 2'd3) st_d = ST_ODD;
            end
            ST_ODD: begin
                nx_we  = 1'b1;
                nx_off = OFF_W'(byte_cnt - CNT_W'(2));
                nx_dat = odd_tail ? held_q : 8'h00;
                st_d   = ST_CTRL;
            end
            ST_CTRL: begin
                nx_we  = 1'b1;
                nx_off = OFF_W'(byte_cnt - CNT_W'(1));
                nx_dat = odd_tail ? CTRL_ODD : CTRL_EVEN;
                st_d   = ST_HDR;
                ptr_d  = '0;
            end
            ST_HDR: begin
                nx_we  = 1'b1;
                nx_off = ptr_q;
                unique case (ptr_q[1:0])
                    2'd0:    nx_dat = status[7:0];
                    2'd1:    nx_dat = status[15:8];
                    2'd2:    nx_dat = byte_cnt[7:0];
                    default: nx_dat = byte_cnt[15:8];
                endcase
                ptr_d = ptr_q + 1'b1;
                if (ptr_q[1:0] == 2'd3) st_d = ST_FIN;
            end
            ST_FIN: begin
                go_done = 1'b1;
                st_d    = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            ptr_q   <= '0;
            page_q  <= '0;
            en_q    <= 1'b0;
            strip_q <= 1'b0;
            held_q  <= 8'h00;
            wr_en   <= 1'b0;
            wr_page <= '0;
            wr_off  <= '0;
            wr_data <= 8'h00;
            rx_done <= 1'b0;
            rx_drop <= 1'b0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
            if (start) begin
                page_q  <= page_sel;
                en_q    <= rx_enable && !soft_reset;
                strip_q <= strip_crc;
            end
            if (take && hold) held_q <= s_data;
            wr_en   <= nx_we;
            wr_page <= start ? page_sel : page_q;
            wr_off  <= nx_off;
            wr_data <= nx_dat;
            rx_done <= go_done;
            rx_drop <= go_drop;
        end
    end
endmodule

// File: rtl/rxpk_chk.sv
module rxpk_chk #(
    parameter int PAGE_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              s_ready,
    input logic              wr_en,
    input logic [PAGE_W-1:0] wr_page,
    input logic              rx_done,
    input logic              rx_drop
);
    assert_done_drop_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(rx_done && rx_drop));

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> $past(wr_en));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);

    assert_page_steady_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> $stable(wr_page));

    assert_drop_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        rx_drop |-> !wr_en);

    assert_busy_before_done_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_done || rx_drop) |-> !$past(s_ready));
endmodule

bind rxpk_top rxpk_chk #(.PAGE_W(PAGE_W)) u_rxpk_chk (
    .clk     (clk),
    .rst     (rst),
    .s_ready (s_ready),
    .wr_en   (wr_en),
    .wr_page (wr_page),
    .rx_done (rx_done),
    .rx_drop (rx_drop)
);

// File: tb/tb_rxpk_top.sv
module tb_rxpk_top;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE      = 2048;
    localparam logic [31:0] POLY = 32'hEDB88320;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_enable = 1'b0, soft_reset = 1'b0, strip_crc = 1'b0;
    logic [1:0] page_sel = '0;
    logic       s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_ready, wr_en, rx_done, rx_drop;
    logic [1:0] wr_page;
    logic [10:0] wr_off;
    logic [7:0] wr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxpk_top dut (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .soft_reset(soft_reset),
        .strip_crc(strip_crc), .page_sel(page_sel), .s_valid(s_valid),
        .s_data(s_data), .s_first(s_first), .s_last(s_last), .s_ready(s_ready),
        .wr_en(wr_en), .wr_page(wr_page), .wr_off(wr_off), .wr_data(wr_data),
        .rx_done(rx_done), .rx_drop(rx_drop)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] frm [0:4095];
    logic [7:0] page_mem [0:PAGE-1];
    int hits [0:PAGE-1];
    int total_wr, done_cnt, drop_cnt, page_bad, cyc, last_wr_cyc, done_gap;
    logic [1:0] exp_page;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (wr_en) begin
                if (wr_page !== exp_page) page_bad++;
                page_mem[wr_off] = wr_data;
                hits[wr_off]++;
                total_wr++;
                last_wr_cyc = cyc;
            end
            if (rx_done) begin
                done_cnt++;
                done_gap = cyc - last_wr_cyc;
            end
            if (rx_drop) drop_cnt++;
        end
    end

    function automatic logic [31:0] ref_crc(input logic [7:0] b [0:4095], input int n);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb = c[0] ^ b[i][k];
                c = c >> 1;
                if (fb) c = c ^ POLY;
            end
        end
        return ~c;
    endfunction

    task automatic clear_page();
        @(posedge clk);
        for (int i = 0; i < PAGE; i++) begin
            page_mem[i] = 8'hA5;
            hits[i] = 0;
        end
        total_wr = 0; done_cnt = 0; drop_cnt = 0; page_bad = 0; done_gap = -1;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit first, input bit last, input bit gaps);
        if (gaps && ($urandom % 4 == 0)) begin
            @(negedge clk);
            s_valid = 1'b0;
            repeat ($urandom % 3) @(negedge clk);
        end
        @(negedge clk);
        s_valid = 1'b1; s_data = b; s_first = first; s_last = last;
        while (s_ready !== 1'b1) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic run_frame(input int len, input bit strip, input bit en,
                             input bit srst, input bit gaps);
        logic [7:0] pd [0:4095];
        int d, cnt, bad, k;
        bit reject, odd_long;
        logic [15:0] st;
        logic [31:0] crc;
        clear_page();
        @(negedge clk);
        rx_enable = en; soft_reset = srst; strip_crc = strip;
        exp_page = 2'($urandom); page_sel = exp_page;
        for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
        for (int i = 0; i < len; i++) send_byte(frm[i], i == 0, i == len - 1, gaps);
        @(negedge clk);
        s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
        check(s_ready == 1'b0, "R10", "ready after last byte", s_ready, 0);
        for (int w = 0; w < 6000 && (done_cnt + drop_cnt) == 0; w++) @(negedge clk);
        repeat (4) @(negedge clk);

        d = (len < 64) ? 64 : (len & ~1);
        cnt = d + 6 + (strip ? 0 : 4);
        reject = !en || srst || cnt > 2048;
        odd_long = (len % 2 == 1) && len >= 64;

        if (reject) begin
            check(drop_cnt == 1 && done_cnt == 0, "R8", "reject pulses drop/done",
                  drop_cnt, 1);
            if (!en || srst)
                check(total_wr == 0, "R1", "writes for disabled frame", total_wr, 0);
            else begin
                bad = 0;
                for (int i = 0; i < 4; i++) bad += hits[i];
                check(bad == 0, "R7", "header writes on oversize", bad, 0);
                check(page_bad == 0, "R9", "page number mismatches", page_bad, 0);
            end
            return;
        end

        for (int i = 0; i < 4096; i++) pd[i] = 8'h00;
        for (int i = 0; i < d; i++) pd[i] = frm[i];
        if (len < 64) for (int i = len; i < 64; i++) pd[i] = 8'h00;
        crc = (len < 64) ? ref_crc(pd, 64) : ref_crc(frm, len);
        st = 16'h0;
        if (len > 1518) st[11] = 1'b1;
        if (len % 2 == 1) st[12] = 1'b1;

        check(done_cnt == 1 && drop_cnt == 0, "R8", "done pulses", done_cnt, 1);
        check(done_gap == 1, "R8", "cycles from final write to done", done_gap, 1);
        check({page_mem[1], page_mem[0]} == st, "R2", "status word",
              {page_mem[1], page_mem[0]}, st);
        check({page_mem[3], page_mem[2]} == 16'(cnt), "R3", "byte count",
              {page_mem[3], page_mem[2]}, cnt);
        bad = -1;
        for (int i = 0; i < d; i++) if (bad < 0 && page_mem[4 + i] !== pd[i]) bad = i;
        check(bad < 0, "R4", "data area first bad index", bad, -1);
        if (!strip) begin
            k = 4 + d;
            check({page_mem[k+3], page_mem[k+2], page_mem[k+1], page_mem[k]} == crc,
                  "R5", "crc bytes",
                  {page_mem[k+3], page_mem[k+2], page_mem[k+1], page_mem[k]}, crc);
        end
        check(page_mem[cnt-2] == (odd_long ? frm[len-1] : 8'h00), "R6", "tail byte",
              page_mem[cnt-2], odd_long ? frm[len-1] : 8'h00);
        check(page_mem[cnt-1] == (odd_long ? 8'h60 : 8'h40), "R6", "control byte",
              page_mem[cnt-1], odd_long ? 8'h60 : 8'h40);
        bad = 0;
        for (int i = 0; i < cnt; i++) if (hits[i] != 1) bad++;
        check(bad == 0 && total_wr == cnt && page_bad == 0, "R9", "write coverage",
              total_wr, cnt);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(s_ready == 1 && wr_en == 0 && rx_done == 0 && rx_drop == 0, "R10",
              "reset state ready/wr/done/drop", {s_ready, wr_en, rx_done, rx_drop}, 4'b1000);

        // R10: stray bytes without a start marker while idle
        clear_page();
        for (int i = 0; i < 3; i++) send_byte(8'h5A, 1'b0, i == 2, 1'b0);
        @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
        repeat (12) @(negedge clk);
        check(total_wr == 0 && done_cnt == 0 && drop_cnt == 0, "R10", "stray bytes effect",
              total_wr + done_cnt + drop_cnt, 0);

        // Directed corner cases
        run_frame(1,    0, 1, 0, 0);   // R4 short odd, R5 crc over pad
        run_frame(63,   0, 1, 0, 0);
        run_frame(64,   0, 1, 0, 0);
        run_frame(65,   0, 1, 0, 0);   // R6 odd long tail
        run_frame(65,   1, 1, 0, 0);   // R5 strip
        run_frame(60,   1, 1, 0, 1);
        run_frame(1518, 0, 1, 0, 0);   // R2 boundary
        run_frame(1519, 1, 1, 0, 0);   // R2 long and odd
        run_frame(100,  0, 0, 0, 0);   // R1 disabled
        run_frame(100,  0, 1, 1, 0);   // R1 soft reset
        run_frame(2039, 0, 1, 0, 0);   // R7 fits exactly
        run_frame(2040, 0, 1, 0, 0);   // R7 oversize with crc
        run_frame(2043, 1, 1, 0, 0);   // R7 fits exactly, stripped
        run_frame(2044, 1, 1, 0, 0);   // R7 oversize, stripped

        // Constrained random frames
        for (int n = 0; n < 40; n++)
            run_frame(1 + ($urandom % 160), 1'($urandom), 1'b1, 1'b0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule